// File: doc/BRIEF.md
# Retriggerable Timer Prescaler and Reload Counter

This block is the front end of a general-purpose timer, running entirely on the system clock. An 8-bit down counter divides the system clock. Each time it passes through zero it toggles a flip-flop, so the resulting tick clock is a square wave with equal high and low times. A 16-bit timer down counter advances on every rising edge of that tick and reloads from its own load register when it underflows.

The prescaler is retriggerable. A write to its count register, any software write to the timer count register, and every timer underflow all restart the prescaler from its load register. Any data that comes with such a write is discarded. This keeps the tick phase aligned with the timer's reload points.

In external-count mode the timer no longer follows the tick. It counts rising edges of an outside event line, which is first sampled by two flip-flops that advance only on tick rising edges. Software reaches the four registers through a flat register bus with a select field, a write strobe, write data and combinational read data.

Top module: `prescale_timer`

## Requirements
- R1: The prescaler count (select code 3) decrements by one on every system clock while it is non-zero and no restart is requested. Its current value reads back on the bus.
- R2: With a prescaler reload value N, the count passes through zero every N+1 clocks, reloading N at that point. The tick toggles at each zero, so its period is 2(N+1) clocks with N+1 of them high.
- R3: A write to select code 3 ignores the bus data and loads the prescaler count from bits 7..0 of the prescaler load register.
- R4: A write to the timer count (select code 1) also restarts the prescaler from its load register. So does every timer underflow.
- R5: The prescaler load register (select code 2) stores write data bits 7..0. It reads back with bit 15 at 1, bits 14..8 at 0, and the stored value in bits 7..0.
- R6: In internal mode (extMode low) the timer count decrements on each tick rising edge. At a tick edge where the count is 0, it reloads from the timer load register and raises `underflow` for exactly one clock. With load value M this repeats every (M+1)·2(N+1) clocks.
- R7: The timer load register (select code 0) stores all 16 write bits. A write to select code 1 ignores the bus data and reloads the timer count from the timer load register.
- R8: In external mode (extMode high) the timer steps once per rising edge of `extIn` seen through a two-stage synchronizer clocked by tick rising edges. Without `extIn` edges the count holds, even though the tick keeps running.
- R9: Synchronous active-high reset clears both counters, both load values, the tick flip-flop, the synchronizer and `underflow`. After reset the prescaler load register reads 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regSel | input | 2 | Register select: 0 timer load, 1 timer count, 2 prescaler load, 3 prescaler count |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register (combinational) |
| extMode | input | 1 | High: timer counts external edges; low: timer counts ticks |
| extIn | input | 1 | External event input |
| tickClk | output | 1 | Divided square-wave tick |
| underflow | output | 1 | One-clock pulse on timer underflow |

## Verification
The bench sweeps prescaler reload values and timer load values over a small grid, including the N=0 fastest case and the full 255 case. For each pair it measures tick period, duty and underflow spacing against the formulas. A design that reloaded one cycle late or early would show periods of 2N or 2(N+2), and one that suppressed the toggle on a timer-driven restart would break the duty check.

Writes to both count registers use data patterns that differ from the load values. An implementation that stored the bus data would read back the wrong value.

External mode is driven with a quiet interval followed by pulse trains. A design that kept counting ticks, or one that counted levels instead of edges, gives the wrong number of underflows or the wrong final count.

// File: rtl/prescale_timer_pkg.sv
package prescale_timer_pkg;

  typedef enum logic [1:0] {
    SEL_TMR_LOAD = 2'd0,
    SEL_TMR_CNT  = 2'd1,
    SEL_PRE_LOAD = 2'd2,
    SEL_PRE_CNT  = 2'd3
  } reg_sel_e;

  // strobes from control to datapath, all valid for one system clock
  typedef struct packed {
    logic preLoadWr;   // capture new prescaler reload value
    logic tmrLoadWr;   // capture new timer reload value
    logic preRestart;  // force prescaler count back to its reload value
    logic preToggle;   // invert the tick flip-flop
    logic tmrReload;   // copy timer reload value into the timer count
    logic tmrStep;     // decrement the timer count
  } strobe_t;

endpackage

// File: rtl/prescale_timer_ctrl.sv
module prescale_timer_ctrl
  import prescale_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       extMode,
  input  logic       extIn,
  input  logic       preZero,
  input  logic       tmrZero,
  input  logic       tickClk,
  output strobe_t    strobes,
  output logic       underflow
);

  logic preCntWr;
  logic tmrCntWr;
  logic tickRise;
  logic extSyncA;
  logic extSyncB;
  logic extEdge;
  logic stepNow;
  logic wrapNow;

  assign preCntWr = wrEn && (reg_sel_e'(regSel) == SEL_PRE_CNT);
  assign tmrCntWr = wrEn && (reg_sel_e'(regSel) == SEL_TMR_CNT);

  // A terminal count toggles the tick unless software restarts the chain.
  // A restart caused by an underflow lands on a terminal count anyway,
  // so it does not block the toggle.
  assign strobes.preToggle = preZero && !preCntWr && !tmrCntWr;
  assign tickRise          = strobes.preToggle && !tickClk;

  // two-stage synchronizer advanced only on tick rising edges
  always_ff @(posedge clk) begin
    if (rst) begin
      extSyncA <= 1'b0;
      extSyncB <= 1'b0;
    end else if (tickRise) begin
      extSyncA <= extIn;
      extSyncB <= extSyncA;
    end
  end

  assign extEdge = tickRise && extSyncA && !extSyncB;
  assign stepNow = extMode ? extEdge : tickRise;
  assign wrapNow = stepNow && tmrZero && !tmrCntWr;

  assign strobes.preLoadWr  = wrEn && (reg_sel_e'(regSel) == SEL_PRE_LOAD);
  assign strobes.tmrLoadWr  = wrEn && (reg_sel_e'(regSel) == SEL_TMR_LOAD);
  assign strobes.tmrReload  = tmrCntWr || wrapNow;
  assign strobes.tmrStep    = stepNow && !tmrCntWr;
  assign strobes.preRestart = preCntWr || strobes.tmrReload;

  always_ff @(posedge clk) begin
    if (rst) underflow <= 1'b0;
    else     underflow <= wrapNow;
  end

endmodule

// File: rtl/prescale_timer_dp.sv
module prescale_timer_dp
  import prescale_timer_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [1:0]       regSel,
  input  logic [TMR_W-1:0] wrData,
  output logic [TMR_W-1:0] rdData,
  output logic             preZero,
  output logic             tmrZero,
  output logic             tickClk,
  output logic [PRE_W-1:0] preCnt,
  output logic [PRE_W-1:0] preLoad,
  output logic [TMR_W-1:0] tmrCnt,
  output logic [TMR_W-1:0] tmrLoad
);

  localparam int PAD_W = TMR_W - PRE_W - 1;

  logic [TMR_W-1:0] preLoadView;
  logic [TMR_W-1:0] preCntView;

  assign preZero = (preCnt == '0);
  assign tmrZero = (tmrCnt == '0);

  // prescaler
  always_ff @(posedge clk) begin
    if (rst) begin
      preLoad <= '0;
      preCnt  <= '0;
    end else begin
      if (strobes.preLoadWr) preLoad <= wrData[PRE_W-1:0];
      if (strobes.preRestart || preZero) preCnt <= preLoad;
      else                               preCnt <= preCnt - 1'b1;
    end
  end

  // divide-by-two stage
  always_ff @(posedge clk) begin
    if (rst)                    tickClk <= 1'b0;
    else if (strobes.preToggle) tickClk <= ~tickClk;
  end

  // timer
  always_ff @(posedge clk) begin
    if (rst) begin
      tmrLoad <= '0;
      tmrCnt  <= '0;
    end else begin
      if (strobes.tmrLoadWr) tmrLoad <= wrData;
      if (strobes.tmrReload)    tmrCnt <= tmrLoad;
      else if (strobes.tmrStep) tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign preLoadView = {1'b1, {PAD_W{1'b0}}, preLoad};
  assign preCntView  = {{(TMR_W-PRE_W){1'b0}}, preCnt};

  always_comb begin
    unique case (reg_sel_e'(regSel))
      SEL_TMR_LOAD: rdData = tmrLoad;
      SEL_TMR_CNT:  rdData = tmrCnt;
      SEL_PRE_LOAD: rdData = preLoadView;
      default:      rdData = preCntView;
    endcase
  end

endmodule

// File: rtl/prescale_timer.sv
module prescale_timer
  import prescale_timer_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [TMR_W-1:0] wrData,
  output logic [TMR_W-1:0] rdData,
  input  logic             extMode,
  input  logic             extIn,
  output logic             tickClk,
  output logic             underflow
);

  strobe_t          strobes;
  logic             preZero;
  logic             tmrZero;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLoad;
  logic [TMR_W-1:0] tmrCnt;
  logic [TMR_W-1:0] tmrLoad;

  prescale_timer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regSel    (regSel),
    .wrEn      (wrEn),
    .extMode   (extMode),
    .extIn     (extIn),
    .preZero   (preZero),
    .tmrZero   (tmrZero),
    .tickClk   (tickClk),
    .strobes   (strobes),
    .underflow (underflow)
  );

  prescale_timer_dp #(.PRE_W(PRE_W), .TMR_W(TMR_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .regSel  (regSel),
    .wrData  (wrData),
    .rdData  (rdData),
    .preZero (preZero),
    .tmrZero (tmrZero),
    .tickClk (tickClk),
    .preCnt  (preCnt),
    .preLoad (preLoad),
    .tmrCnt  (tmrCnt),
    .tmrLoad (tmrLoad)
  );

endmodule

// File: rtl/prescale_timer_chk.sv
module prescale_timer_chk #(
  parameter int PRE_W = 8,
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       regSel,
  input logic             wrEn,
  input logic [TMR_W-1:0] rdData,
  input logic             tickClk,
  input logic             underflow,
  input logic [PRE_W-1:0] preCnt,
  input logic [PRE_W-1:0] preLoad,
  input logic [TMR_W-1:0] tmrCnt,
  input logic [TMR_W-1:0] tmrLoad
);

  AST_PRE_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (preCnt != '0 && !wrEn) |=> preCnt == $past(preCnt) - 1'b1); // R1

  AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tickClk != $past(tickClk)) |-> $past(preCnt) == '0); // R2

  AST_PRE_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regSel == 2'd3) |=> preCnt == $past(preLoad)); // R3

  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (preCnt == $past(preLoad)) && (tmrCnt == $past(tmrLoad))); // R4

  AST_LOAD_VIEW: assert property (@(posedge clk) disable iff (rst)
    (regSel == 2'd2) |-> rdData[TMR_W-1:PRE_W] == {1'b1, {(TMR_W-PRE_W-1){1'b0}}}); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    underflow |=> !underflow); // R6

  AST_TMR_WRITE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regSel == 2'd1) |=> tmrCnt == $past(tmrLoad)); // R7

endmodule

bind prescale_timer prescale_timer_chk #(.PRE_W(PRE_W), .TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regSel    (regSel),
  .wrEn      (wrEn),
  .rdData    (rdData),
  .tickClk   (tickClk),
  .underflow (underflow),
  .preCnt    (preCnt),
  .preLoad   (preLoad),
  .tmrCnt    (tmrCnt),
  .tmrLoad   (tmrLoad)
);

// File: tb/prescale_timer_bench.sv
`timescale 1ns/1ps
module prescale_timer_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  regSel;
  logic        wrEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        extMode;
  logic        extIn;
  logic        tickClk;
  logic        underflow;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prescale_timer u_prescale_timer (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .extMode(extMode), .extIn(extIn),
    .tickClk(tickClk), .underflow(underflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int val);
    regSel = sel;
    #1;
    val = int'(rdData);
  endtask

  // tick period and high time, sampled at falling clock edges
  task automatic measureTick(output int per, output int hi);
    int prev;
    int guard;
    prev = int'(tickClk);
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
      if (prev == 0 && tickClk) break;
      prev = int'(tickClk);
    end while (guard < 5000);
    per = 0; hi = 1; prev = 1;
    do begin
      @(negedge clk);
      per++;
      if (prev == 0 && tickClk) break;
      if (tickClk) hi++;
      prev = int'(tickClk);
    end while (per < 5000);
  endtask

  task automatic measureWrap(output int gap, output int width);
    int guard;
    guard = 0;
    while (!underflow && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    width = underflow ? 2 : 1;
    gap = 1;
    while (!underflow && gap < 20000) begin @(negedge clk); gap++; end
  endtask

  task automatic sweepPoint(input int n, input int m);
    int v, per, hi, gap, width;
    wr(2'd2, 16'h7F00 | 16'(n));
    rd(2'd2, v);
    chk("R5 load view", v, 32768 + n);
    wr(2'd0, 16'(m));
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v);
    chk("R7 timer write reload", v, m);
    rd(2'd3, v);
    chk("R4 timer write restarts prescaler", v, n);
    wr(2'd3, 16'h55AA);
    rd(2'd3, v);
    chk("R3 prescaler write ignores data", v, n);
    @(negedge clk);
    rd(2'd3, v);
    chk("R1 prescaler decrement", v, (n == 0) ? 0 : n - 1);
    measureTick(per, hi);
    chk("R2 tick period", per, 2 * (n + 1));
    chk("R2 tick high time", hi, n + 1);
    measureWrap(gap, width);
    chk("R6 underflow spacing", gap, (m + 1) * 2 * (n + 1));
    chk("R6 underflow width", width, 1);
    @(negedge clk);
    rd(2'd3, v);
    chk("R4 underflow restarts prescaler", v, (n == 0) ? 0 : n - 1);
  endtask

  task automatic pulses(input int count, output int wraps);
    wraps = 0;
    for (int p = 0; p < count; p++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        extIn = (c < 8);
        if (underflow) wraps++;
      end
    end
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (underflow) wraps++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int v, wraps;
    rst = 1'b1; regSel = 2'd0; wrEn = 1'b0; wrData = '0; extMode = 1'b0; extIn = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R9 reset timer load", v, 0);
    rd(2'd1, v); chk("R9 reset timer count", v, 0);
    rd(2'd2, v); chk("R9 reset prescaler load view", v, 32768);
    rd(2'd3, v); chk("R9 reset prescaler count", v, 0);
    chk("R9 reset tick", int'(tickClk), 0);
    chk("R9 reset underflow", int'(underflow), 0);
    rst = 1'b0;

    for (int n = 0; n < 5; n++)
      for (int m = 0; m < 4; m++)
        sweepPoint(n, m);
    sweepPoint(255, 0);
    sweepPoint(7, 2);

    // external event counting: fastest tick, load 2
    extMode = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'h1234);
    repeat (40) @(negedge clk);
    rd(2'd1, v);
    chk("R8 timer holds without external edges", v, 2);
    pulses(6, wraps);
    chk("R8 underflows after six edges", wraps, 2);
    rd(2'd1, v);
    chk("R8 count after six edges", v, 2);
    pulses(4, wraps);
    chk("R8 underflows after four edges", wraps, 1);
    rd(2'd1, v);
    chk("R8 count after four more edges", v, 1);
    extIn = 1'b1;
    repeat (40) @(negedge clk);
    rd(2'd1, v);
    chk("R8 steady high level is one edge", v, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule